// File: doc/BRIEF.md
# Event Flag Interrupt Controller

This block gathers sixteen single-bit event indications into readable flag bytes and turns selected ones into a shared, active-low interrupt request for a host processor. Every event has an enable bit. While the enable bit is set, the event's flag works as a sticky latch. A rising edge of the synchronized source sets it, the latch holds until software clears it, and a set latch pulls the interrupt request low. While the enable bit is clear, the flag is a plain status mirror of the synchronized source level, and it never touches the interrupt request.

The host reaches the enables and flags through a small byte-wide register port. Writes are single-cycle strobes and reads are combinational. Software acknowledges a latched event by writing a one to its flag bit. A synchronous soft-clear input and the asynchronous reset both discard all latched state. An extra input vector merges other interrupt causes into the same request line. The output is registered, so it is free of glitches and can feed an open-drain pad driver placed outside the block.

Top module: `evirq_ctrl`

## Requirements
- R1: With its enable bit at 1, a flag is set by a rising edge of its source. When the source goes high at clock edge n, the flag reads 1 after edge n+2. It then stays 1 after the source falls.
- R2: With its enable bit at 0, a flag reads the current source level two edges late, and it falls again when the source falls.
- R3: A flag whose enable bit is 0 never pulls `irq_no` low, whatever its source does.
- R4: Writing 1 to a latched flag bit clears it. Writing 0 to it leaves it set.
- R5: `irq_no` is active low and registered. It goes low one edge after any enabled flag is latched, or one edge after any `ext_irq_i` bit is 1. It returns high one edge after the last such cause is gone.
- R6: A rising edge and a write-1-to-clear on the same flag in the same cycle leave the flag set.
- R7: Clearing an enable bit while its flag is latched discards the latch. Reads then show the live source level, `irq_no` returns high on the next edge, and re-enabling does not bring the old event back.
- R8: A one-cycle `soft_clr_i` clears every latched flag and wins over a simultaneous edge. `rst_ni` low clears enables, flags and the request asynchronously.
- R9: Byte addresses 0x04 and 0x05 hold the enable bits for events 7..0 and 15..8, and 0x06 and 0x07 hold the flags for events 7..0 and 15..8. Bit k of a byte belongs to event (8 × byte index + k). Reads return the current contents. Other addresses read 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| soft_clr_i | input | 1 | Synchronous clear of all latched flags |
| evt_src_i | input | 16 | Asynchronous event source levels |
| ext_irq_i | input | 1 | Other interrupt causes merged into the request |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| irq_no | output | 1 | Interrupt request, active low |

## Verification
The hardest case to reach is the collision of R6. The write-1-to-clear strobe must land on the exact edge where the synchronized rising edge is being detected. That edge is two stages behind the pin. The bench raises the source on a falling clock edge, lets two rising edges pass, and then presents the clear write so that it commits on the third edge. After that it reads the flag back. A second awkward case is disabling an event while its flag is latched. The bench checks the readback and the request on the write edge, and again one edge later, to show that the latch was discarded and not merely masked.

// File: rtl/evirq_pkg.sv
package evirq_pkg;

   // How a single flag bit behaves, picked by its enable bit
   typedef enum logic {
      FLAG_LIVE   = 1'b0,   // mirrors the synchronized source
      FLAG_STICKY = 1'b1    // latches on a rising edge
   } flag_mode_e;

   localparam int unsigned DEF_N_EVT      = 16;
   localparam int unsigned DEF_BYTE_W     = 8;
   localparam int unsigned DEF_ADDR_W     = 8;
   localparam int unsigned DEF_SYNC_DEPTH = 2;
   localparam int unsigned DEF_N_EXT      = 1;

   function automatic flag_mode_e mode_of(input logic en);
      return en ? FLAG_STICKY : FLAG_LIVE;
   endfunction

endpackage

// File: rtl/evirq_sync.sv
module evirq_sync #(
   parameter int unsigned N     = 16,
   parameter int unsigned DEPTH = 2
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [N-1:0] async_i,
   output logic [N-1:0] level_o,
   output logic [N-1:0] rise_o
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("evirq_sync: DEPTH must be at least 2");
   end

   logic [N-1:0] stage_q [DEPTH];
   logic [N-1:0] prev_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int s = 0; s < int'(DEPTH); s++) stage_q[s] <= '0;
         prev_q <= '0;
      end else begin
         stage_q[0] <= async_i;
         for (int s = 1; s < int'(DEPTH); s++) stage_q[s] <= stage_q[s-1];
         prev_q <= stage_q[DEPTH-1];
      end
   end

   assign level_o = stage_q[DEPTH-1];
   assign rise_o  = stage_q[DEPTH-1] & ~prev_q;

endmodule

// File: rtl/evirq_flag_bit.sv
module evirq_flag_bit
   import evirq_pkg::*;
(
   input  logic clk_i,
   input  logic rst_ni,
   input  logic en_i,
   input  logic rise_i,
   input  logic level_i,
   input  logic clr_i,
   input  logic soft_clr_i,
   output logic lat_o,
   output logic rd_o,
   output logic req_o
);

   flag_mode_e mode;
   logic       lat_q;

   assign mode = mode_of(en_i);

   // Priority: soft clear, disabled mode, set edge, then write-1 clear
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 lat_q <= 1'b0;
      else if (soft_clr_i)         lat_q <= 1'b0;
      else if (mode == FLAG_LIVE)  lat_q <= 1'b0;
      else if (rise_i)             lat_q <= 1'b1;
      else if (clr_i)              lat_q <= 1'b0;
   end

   assign lat_o = lat_q;
   assign rd_o  = (mode == FLAG_STICKY) ? lat_q : level_i;
   assign req_o = (mode == FLAG_STICKY) & lat_q;

endmodule

// File: rtl/evirq_regfile.sv
module evirq_regfile #(
   parameter int unsigned          N_EVT     = 16,
   parameter int unsigned          BYTE_W    = 8,
   parameter int unsigned          ADDR_W    = 8,
   parameter logic [ADDR_W-1:0]    EN_BASE   = 'h04,
   parameter logic [ADDR_W-1:0]    FLAG_BASE = 'h06
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [BYTE_W-1:0] wdata_i,
   input  logic [N_EVT-1:0]  flag_rd_i,
   output logic [N_EVT-1:0]  en_o,
   output logic [N_EVT-1:0]  clr_o,
   output logic [BYTE_W-1:0] rdata_o
);

   localparam int unsigned N_BANK = N_EVT / BYTE_W;

   logic [N_EVT-1:0] en_q;
   logic [N_BANK-1:0] en_hit, flag_hit;

   for (genvar b = 0; b < int'(N_BANK); b++) begin : g_bank
      assign en_hit[b]   = (addr_i == ADDR_W'(EN_BASE + b));
      assign flag_hit[b] = (addr_i == ADDR_W'(FLAG_BASE + b));

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)
            en_q[b*BYTE_W +: BYTE_W] <= '0;
         else if (wr_i && en_hit[b])
            en_q[b*BYTE_W +: BYTE_W] <= wdata_i;
      end

      assign clr_o[b*BYTE_W +: BYTE_W] = (wr_i && flag_hit[b]) ? wdata_i : '0;
   end

   always_comb begin
      rdata_o = '0;
      for (int b = 0; b < int'(N_BANK); b++) begin
         if (en_hit[b])   rdata_o = en_q[b*BYTE_W +: BYTE_W];
         if (flag_hit[b]) rdata_o = flag_rd_i[b*BYTE_W +: BYTE_W];
      end
   end

   assign en_o = en_q;

endmodule

// File: rtl/evirq_ctrl.sv
module evirq_ctrl
   import evirq_pkg::*;
#(
   parameter int unsigned       N_EVT      = DEF_N_EVT,
   parameter int unsigned       BYTE_W     = DEF_BYTE_W,
   parameter int unsigned       ADDR_W     = DEF_ADDR_W,
   parameter int unsigned       SYNC_DEPTH = DEF_SYNC_DEPTH,
   parameter int unsigned       N_EXT      = DEF_N_EXT,
   parameter logic [ADDR_W-1:0] EN_BASE    = 'h04,
   parameter logic [ADDR_W-1:0] FLAG_BASE  = 'h06
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              soft_clr_i,
   input  logic [N_EVT-1:0]  evt_src_i,
   input  logic [N_EXT-1:0]  ext_irq_i,
   input  logic              reg_wr_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic [BYTE_W-1:0] reg_wdata_i,
   output logic [BYTE_W-1:0] reg_rdata_o,
   output logic              irq_no
);

   localparam int unsigned N_BANK = N_EVT / BYTE_W;

   if (N_EVT % BYTE_W != 0) begin : g_bad_split
      $error("evirq_ctrl: N_EVT must be a multiple of BYTE_W");
   end
   if (!((int'(FLAG_BASE) >= int'(EN_BASE) + int'(N_BANK)) ||
         (int'(EN_BASE) >= int'(FLAG_BASE) + int'(N_BANK)))) begin : g_bad_map
      $error("evirq_ctrl: enable and flag address windows overlap");
   end
   if (N_EXT < 1) begin : g_bad_ext
      $error("evirq_ctrl: N_EXT must be at least 1");
   end

   logic [N_EVT-1:0] level_vec, rise_vec, en_vec, clr_vec;
   logic [N_EVT-1:0] lat_vec, rd_vec, req_vec;
   logic             irq_q;

   evirq_sync #(.N(N_EVT), .DEPTH(SYNC_DEPTH)) u_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .async_i (evt_src_i),
      .level_o (level_vec),
      .rise_o  (rise_vec)
   );

   evirq_regfile #(
      .N_EVT(N_EVT), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W),
      .EN_BASE(EN_BASE), .FLAG_BASE(FLAG_BASE)
   ) u_regs (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (reg_wr_i),
      .addr_i    (reg_addr_i),
      .wdata_i   (reg_wdata_i),
      .flag_rd_i (rd_vec),
      .en_o      (en_vec),
      .clr_o     (clr_vec),
      .rdata_o   (reg_rdata_o)
   );

   for (genvar i = 0; i < int'(N_EVT); i++) begin : g_flag
      evirq_flag_bit u_bit (
         .clk_i      (clk_i),
         .rst_ni     (rst_ni),
         .en_i       (en_vec[i]),
         .rise_i     (rise_vec[i]),
         .level_i    (level_vec[i]),
         .clr_i      (clr_vec[i]),
         .soft_clr_i (soft_clr_i),
         .lat_o      (lat_vec[i]),
         .rd_o       (rd_vec[i]),
         .req_o      (req_vec[i])
      );
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) irq_q <= 1'b0;
      else         irq_q <= (|req_vec) | (|ext_irq_i);
   end

   assign irq_no = ~irq_q;

endmodule

// File: rtl/evirq_ctrl_chk.sv
module evirq_ctrl_chk #(
   parameter int unsigned N_EVT = 16,
   parameter int unsigned N_EXT = 1
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             soft_clr_i,
   input logic [N_EVT-1:0] en,
   input logic [N_EVT-1:0] lat,
   input logic [N_EVT-1:0] rise,
   input logic [N_EVT-1:0] clr,
   input logic [N_EXT-1:0] ext_irq_i,
   input logic             irq_no
);

   AST_SET_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !soft_clr_i |=> ((lat & $past(rise & en)) == $past(rise & en))); // R1

   AST_SET_BEATS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!soft_clr_i && ((rise & en & clr) != '0)) |=> ((lat & $past(rise & clr)) != '0)); // R6

   AST_HOLD_UNTIL_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !soft_clr_i |=> ((~lat & $past(lat & en & ~clr)) == '0)); // R4

   AST_DISABLED_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> ((lat & ~$past(en)) == '0)); // R7

   AST_IRQ_TRACKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> (irq_no == !($past((lat & en) != '0) || $past(ext_irq_i != '0)))); // R5

   AST_QUIET_WHEN_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((en == '0) && (ext_irq_i == '0)) |=> irq_no); // R3

   AST_SOFT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      soft_clr_i |=> (lat == '0)); // R8

endmodule

bind evirq_ctrl evirq_ctrl_chk #(.N_EVT(N_EVT), .N_EXT(N_EXT)) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .soft_clr_i (soft_clr_i),
   .en         (en_vec),
   .lat        (lat_vec),
   .rise       (rise_vec),
   .clr        (clr_vec),
   .ext_irq_i  (ext_irq_i),
   .irq_no     (irq_no)
);

// File: tb/evirq_ctrl_test.sv
`timescale 1ns/1ps
module evirq_ctrl_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        soft_clr = 1'b0;
   logic [15:0] src = '0;
   logic [0:0]  ext = '0;
   logic        wr = 1'b0;
   logic [7:0]  addr = '0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic        irq_n;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;

   evirq_ctrl uut (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .soft_clr_i  (soft_clr),
      .evt_src_i   (src),
      .ext_irq_i   (ext),
      .reg_wr_i    (wr),
      .reg_addr_i  (addr),
      .reg_wdata_i (wdata),
      .reg_rdata_o (rdata),
      .irq_no      (irq_n)
   );

   task automatic check(input string req, input string what,
                        input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
      wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr = 1'b0; wdata = '0;
   endtask

   task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
      addr = a;
      #1 d = rdata;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; src = '0; ext = '0; soft_clr = 1'b0;
      step(2);
      rst_n = 1'b1;
      step(1);
   endtask

   task automatic t_reset_state();
      logic [7:0] d;
      for (int a = 4; a < 8; a++) begin
         rd_reg(8'(a), d);
         check("R8", $sformatf("reset value at %0h", a), d, 8'h00);
      end
      check("R5", "irq idle after reset", {7'b0, irq_n}, 8'h01);
   endtask

   task automatic t_regmap();
      logic [7:0] d;
      wr_reg(8'h04, 8'hA5);
      wr_reg(8'h05, 8'h3C);
      rd_reg(8'h04, d); check("R9", "enable low byte", d, 8'hA5);
      rd_reg(8'h05, d); check("R9", "enable high byte", d, 8'h3C);
      wr_reg(8'h03, 8'hFF);
      wr_reg(8'h08, 8'hFF);
      rd_reg(8'h03, d); check("R9", "unmapped read", d, 8'h00);
      rd_reg(8'h04, d); check("R9", "enable unchanged by stray write", d, 8'hA5);
      rd_reg(8'h05, d); check("R9", "enable high unchanged", d, 8'h3C);
      wr_reg(8'h04, 8'h00);
      wr_reg(8'h05, 8'h00);
   endtask

   task automatic t_latch_enabled();
      logic [7:0] d;
      wr_reg(8'h04, 8'h08);           // enable event 3
      src[3] = 1'b1;
      step(2);
      rd_reg(8'h06, d); check("R1", "not yet latched after 2 edges", d, 8'h00);
      step(1);
      rd_reg(8'h06, d); check("R1", "latched after 3 edges", d, 8'h08);
      check("R5", "irq still high before register", {7'b0, irq_n}, 8'h01);
      step(1);
      check("R5", "irq low one edge after latch", {7'b0, irq_n}, 8'h00);
      src[3] = 1'b0;
      step(4);
      rd_reg(8'h06, d); check("R1", "held after source fell", d, 8'h08);
   endtask

   task automatic t_clear();
      logic [7:0] d;
      wr_reg(8'h06, 8'h00);
      rd_reg(8'h06, d); check("R4", "write 0 keeps flag", d, 8'h08);
      wr_reg(8'h06, 8'hF7);
      rd_reg(8'h06, d); check("R4", "write 1 elsewhere keeps flag", d, 8'h08);
      wr_reg(8'h06, 8'h08);
      rd_reg(8'h06, d); check("R4", "write 1 clears flag", d, 8'h00);
      check("R5", "irq still low on clear edge", {7'b0, irq_n}, 8'h00);
      step(1);
      check("R5", "irq high one edge after clear", {7'b0, irq_n}, 8'h01);
      wr_reg(8'h04, 8'h00);
   endtask

   task automatic t_mirror_disabled();
      logic [7:0] d;
      src[10] = 1'b1;
      step(1);
      rd_reg(8'h07, d); check("R2", "mirror lags by two edges", d, 8'h00);
      step(1);
      rd_reg(8'h07, d); check("R2", "mirror shows level", d, 8'h04);
      step(3);
      check("R3", "disabled flag leaves irq high", {7'b0, irq_n}, 8'h01);
      src[10] = 1'b0;
      step(2);
      rd_reg(8'h07, d); check("R2", "mirror follows fall", d, 8'h00);
      check("R3", "irq still high", {7'b0, irq_n}, 8'h01);
   endtask

   task automatic t_same_cycle();
      logic [7:0] d;
      wr_reg(8'h05, 8'h01);           // enable event 8
      src[8] = 1'b1;
      step(2);                        // edge detect active before next edge
      wr_reg(8'h07, 8'h01);           // clear commits on the detect edge
      rd_reg(8'h07, d); check("R6", "set wins over clear", d, 8'h01);
      src[8] = 1'b0;
      wr_reg(8'h07, 8'h01);
      rd_reg(8'h07, d); check("R4", "later clear works", d, 8'h00);
      wr_reg(8'h05, 8'h00);
      step(2);
   endtask

   task automatic t_disable_latched();
      logic [7:0] d;
      wr_reg(8'h04, 8'h01);
      src[0] = 1'b1;
      step(3);
      src[0] = 1'b0;
      step(3);
      rd_reg(8'h06, d); check("R1", "event 0 latched", d, 8'h01);
      check("R5", "irq low", {7'b0, irq_n}, 8'h00);
      wr_reg(8'h04, 8'h00);
      rd_reg(8'h06, d); check("R7", "disabled read shows live level", d, 8'h00);
      step(1);
      check("R7", "irq high after disable", {7'b0, irq_n}, 8'h01);
      wr_reg(8'h04, 8'h01);
      step(1);
      rd_reg(8'h06, d); check("R7", "latch discarded on re-enable", d, 8'h00);
      check("R7", "irq stays high on re-enable", {7'b0, irq_n}, 8'h01);
      wr_reg(8'h04, 8'h00);
   endtask

   task automatic t_soft_clear();
      logic [7:0] d;
      wr_reg(8'h04, 8'h02);
      wr_reg(8'h05, 8'h80);
      src[1] = 1'b1; src[15] = 1'b1;
      step(4);
      rd_reg(8'h06, d); check("R8", "event 1 latched", d, 8'h02);
      rd_reg(8'h07, d); check("R8", "event 15 latched", d, 8'h80);
      soft_clr = 1'b1;
      step(1);
      soft_clr = 1'b0;
      rd_reg(8'h06, d); check("R8", "soft clear low byte", d, 8'h00);
      rd_reg(8'h07, d); check("R8", "soft clear high byte", d, 8'h00);
      step(1);
      check("R8", "irq high after soft clear", {7'b0, irq_n}, 8'h01);
      rd_reg(8'h04, d); check("R8", "enables kept", d, 8'h02);
      src = '0;
      wr_reg(8'h04, 8'h00);
      wr_reg(8'h05, 8'h00);
      step(2);
   endtask

   task automatic t_external();
      ext = 1'b1;
      step(1);
      check("R5", "external cause pulls irq low", {7'b0, irq_n}, 8'h00);
      ext = 1'b0;
      step(1);
      check("R5", "irq released after external cause", {7'b0, irq_n}, 8'h01);
   endtask

   task automatic t_async_reset();
      logic [7:0] d;
      wr_reg(8'h04, 8'h10);
      src[4] = 1'b1;
      step(4);
      #2 rst_n = 1'b0;
      #1;
      check("R8", "irq released by reset", {7'b0, irq_n}, 8'h01);
      rd_reg(8'h04, d); check("R8", "enables cleared by reset", d, 8'h00);
      src = '0;
      step(1);
      rst_n = 1'b1;
      step(1);
   endtask

   initial begin
      do_reset();
      t_reset_state();
      t_regmap();
      t_latch_enabled();
      t_clear();
      t_mirror_disabled();
      t_same_cycle();
      t_disable_latched();
      t_soft_clear();
      t_external();
      t_async_reset();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule